// File: doc/BRIEF.md
# Ping-Pong Banked Tile Feeder

This block keeps two complete copies of a matrix tile and feeds one column of a systolic array from them. A vector loader streams beats into the side being written. Meanwhile each array row has its own request port and its own reply port, and these read bursts from the other side through a crossbar. A single side-select bit picks which physical memory is read and which is written. The two sides never share an array, so a write and a read can never address the same storage.

Each request carries a row address. It is turned into a bank-local base, and the port then returns a fixed run of consecutive words, one per reply handshake. The processing elements report per-row completion. When every row has reported, the block sends a single acknowledge pulse to all rows. The sides swap once the loader has delivered its full quota and every row has reported completion. The first fill is the exception: it swaps as soon as its quota arrives.

The control is a two-state machine. In `ST_PRIME`, only loading takes place. In `ST_SERVE`, loading and serving run together. There are two named transitions. Transition `T_FIRST_SWAP` goes from `ST_PRIME` to `ST_SERVE` when the first quota is met. Transition `T_SWAP` goes from `ST_SERVE` back to `ST_SERVE` when the quota is met and all rows are done.

Top module: `pingpong_tile_feeder`

## Requirements
- R1: There are two physical sides, chosen by one select bit that toggles on every swap. Loader beats write the side that is not being read. Replies always come from the read side, so data loaded in fill n is returned only after the swap that follows fill n.
- R2: A port raises `rq_ready` only while it is serving, not busy and not swapping. An accepted request makes the port busy, and `rq_ready` stays low until its burst ends.
- R3: A row address `a` accepted on port `a mod ROWS` selects bank `a mod ROWS` at base `(a / ROWS) * BURST_LEN`, where `BURST_LEN = STRIPE * VEC`.
- R4: A busy port presents the word at base + k of its read-side bank, with k counting from 0. k advances only on a cycle where `rs_valid` and `rs_ready` are both high. After `BURST_LEN` words the port leaves the busy state.
- R5: A loader beat carries VEC words, with lane l in bits `[l*DATA_W +: DATA_W]`. Beat number c (counted from 0 within a fill) goes to bank `(c / STRIPE) mod ROWS`. Its lanes are written at that bank's fill pointer plus l, and the pointer then advances by VEC.
- R6: `ld_ready` is low once QUOTA beats have been taken in the current fill, and stays low until the next swap.
- R7: Each row's completion is latched. `dn_ready` for a row is low while its flag is set and during `ST_PRIME`. When all flags are set, `ack` is high on every row for exactly one cycle.
- R8: A swap happens only when the quota is met and either all rows are done or the state is `ST_PRIME`. It clears the beat count, the fill pointers, all busy flags, all done flags and the acknowledge record.
- R9: Before the first swap, `rq_ready` and `rs_valid` are low on every port.
- R10: In a swap cycle, `rs_valid` and `rq_ready` are low on every port. A burst still in flight is dropped, and its port is idle after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Loader beat valid |
| ld_ready | output | 1 | Loader beat accepted when high with valid |
| ld_data | input | VEC*DATA_W | Loader beat, lane l in bits l*DATA_W upward |
| rq_valid | input | ROWS | Per-port request valid |
| rq_ready | output | ROWS | Per-port request ready |
| rq_addr | input | ROWS*REQ_W | Per-port row address, port p in bits p*REQ_W upward |
| rs_valid | output | ROWS | Per-port reply valid |
| rs_ready | input | ROWS | Per-port reply ready |
| rs_data | output | ROWS*DATA_W | Per-port reply word |
| dn_valid | input | ROWS | Per-row completion valid |
| dn_ready | output | ROWS | Per-row completion ready |
| ack | output | ROWS | One-cycle acknowledge to every row |

## Verification
The bench builds the block with ROWS=2, DATA_W=8, VEC=2, STRIPE=2 and QUOTA=8. With these values each bank holds 8 words and each burst is 4 words. Every row address from 0 to 3 is swept across four fills, so every bank word on both sides is written and read back with values computed from the fill number, beat number and lane. At this size the bench can also drive the orderings that matter: completion arriving before or after the quota, a burst cut off by a swap, and reply back-pressure in the middle of a burst.

// File: rtl/feeder_pkg.sv
package feeder_pkg;
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_SERVE = 1'b1
    } feed_state_t;
endpackage

// File: rtl/feeder_store.sv
module feeder_store #(
    parameter int ROWS       = 2,
    parameter int DATA_W     = 8,
    parameter int VEC        = 2,
    parameter int BANK_WORDS = 8,
    parameter int AW         = 3,
    parameter int BW         = 1
) (
    input  logic                   clk,
    input  logic                   rd_side,
    input  logic                   wr_en,
    input  logic [BW-1:0]          wr_bank,
    input  logic [AW-1:0]          wr_ptr,
    input  logic [VEC*DATA_W-1:0]  wr_data,
    input  logic [ROWS*AW-1:0]     rd_addr,
    output logic [ROWS*DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] side0 [ROWS][BANK_WORDS];
    logic [DATA_W-1:0] side1 [ROWS][BANK_WORDS];

    // Writes land on the side that is not being read.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < VEC; l++) begin
                if (rd_side) begin
                    side0[wr_bank][wr_ptr + AW'(l)] <= wr_data[l*DATA_W +: DATA_W];
                end else begin
                    side1[wr_bank][wr_ptr + AW'(l)] <= wr_data[l*DATA_W +: DATA_W];
                end
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_rd
        logic [AW-1:0] a;
        assign a = rd_addr[r*AW +: AW];
        assign rd_data[r*DATA_W +: DATA_W] = rd_side ? side1[r][a] : side0[r][a];
    end
endmodule

// File: rtl/feeder_fill_seq.sv
module feeder_fill_seq #(
    parameter int ROWS   = 2,
    parameter int VEC    = 2,
    parameter int STRIPE = 2,
    parameter int QUOTA  = 8,
    parameter int AW     = 3,
    parameter int BW     = 1,
    parameter int CW     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          swap,
    input  logic          ld_valid,
    output logic          ld_ready,
    output logic          wr_en,
    output logic [BW-1:0] wr_bank,
    output logic [AW-1:0] wr_ptr,
    output logic          quota_met
);
    logic [CW-1:0] wcount_q;
    logic [AW-1:0] ptr_q [ROWS];

    assign quota_met = (wcount_q == CW'(QUOTA));
    assign ld_ready  = !quota_met;
    assign wr_en     = ld_valid && ld_ready;
    assign wr_bank   = BW'((int'(wcount_q) / STRIPE) % ROWS);
    assign wr_ptr    = ptr_q[wr_bank];

    always_ff @(posedge clk) begin
        if (!rst_n || swap) begin
            wcount_q <= '0;
            for (int b = 0; b < ROWS; b++) ptr_q[b] <= '0;
        end else if (wr_en) begin
            wcount_q         <= wcount_q + 1'b1;
            ptr_q[wr_bank]   <= ptr_q[wr_bank] + AW'(VEC);
        end
    end

    assert_quota_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wcount_q <= CW'(QUOTA));
    assert_beat_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wcount_q == $past(wcount_q) + 1'b1);
endmodule

// File: rtl/feeder_burst_port.sv
module feeder_burst_port #(
    parameter int ROWS      = 2,
    parameter int REQ_W     = 4,
    parameter int BURST_LEN = 4,
    parameter int AW        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serving,
    input  logic             swap,
    input  logic             rq_valid,
    output logic             rq_ready,
    input  logic [REQ_W-1:0] rq_addr,
    output logic             rs_valid,
    input  logic             rs_ready,
    output logic [AW-1:0]    rd_addr
);
    localparam int LW = $clog2(BURST_LEN + 1);

    logic          busy_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] len_q;
    logic          rq_fire, rs_fire, last;

    assign rq_ready = serving && !busy_q && !swap;
    assign rs_valid = busy_q && !swap;
    assign rq_fire  = rq_valid && rq_ready;
    assign rs_fire  = rs_valid && rs_ready;
    assign last     = (len_q == LW'(BURST_LEN - 1));
    assign rd_addr  = base_q + AW'(len_q);

    always_ff @(posedge clk) begin
        if (!rst_n || swap) begin
            busy_q <= 1'b0;
            base_q <= '0;
            len_q  <= '0;
        end else if (rq_fire) begin
            busy_q <= 1'b1;
            base_q <= AW'((int'(rq_addr) / ROWS) * BURST_LEN);
            len_q  <= '0;
        end else if (rs_fire) begin
            len_q <= len_q + 1'b1;
            if (last) busy_q <= 1'b0;
        end
    end

    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rq_fire |=> !rq_ready);
    assert_burst_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_fire && last) |=> !rs_valid);
    assert_swap_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> !rs_valid);
endmodule

// File: rtl/feeder_swap_ctl.sv
module feeder_swap_ctl
    import feeder_pkg::*;
#(
    parameter int ROWS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            quota_met,
    input  logic [ROWS-1:0] dn_valid,
    output logic [ROWS-1:0] dn_ready,
    output logic [ROWS-1:0] ack,
    output logic            swap,
    output logic            serving,
    output logic            rd_side
);
    feed_state_t     state_q, state_d;
    logic [ROWS-1:0] done_q;
    logic            acked_q;
    logic            all_done;

    assign all_done = &done_q;

    // Transition logic: T_FIRST_SWAP and T_SWAP.
    always_comb begin
        state_d = state_q;
        swap    = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                if (quota_met) begin
                    swap    = 1'b1;
                    state_d = ST_SERVE;
                end
            end
            ST_SERVE: begin
                if (quota_met && all_done) swap = 1'b1;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    // Outputs.
    always_comb begin
        serving  = (state_q == ST_SERVE);
        dn_ready = serving ? ~done_q : '0;
        ack      = (serving && all_done && !acked_q) ? '1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_side <= 1'b0;
            done_q  <= '0;
            acked_q <= 1'b0;
        end else if (swap) begin
            rd_side <= !rd_side;
            done_q  <= '0;
            acked_q <= 1'b0;
        end else begin
            done_q <= done_q | (dn_valid & dn_ready);
            if (ack[0]) acked_q <= 1'b1;
        end
    end

    assert_side_flip_R1: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> rd_side != $past(rd_side));
    assert_swap_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> dn_ready == '1);
    assert_ack_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != '0) |=> ack == '0);
endmodule

// File: rtl/pingpong_tile_feeder.sv
module pingpong_tile_feeder #(
    parameter int ROWS   = 2,
    parameter int DATA_W = 8,
    parameter int VEC    = 2,
    parameter int STRIPE = 2,
    parameter int QUOTA  = 8,
    parameter int REQ_W  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld_valid,
    output logic                   ld_ready,
    input  logic [VEC*DATA_W-1:0]  ld_data,
    input  logic [ROWS-1:0]        rq_valid,
    output logic [ROWS-1:0]        rq_ready,
    input  logic [ROWS*REQ_W-1:0]  rq_addr,
    output logic [ROWS-1:0]        rs_valid,
    input  logic [ROWS-1:0]        rs_ready,
    output logic [ROWS*DATA_W-1:0] rs_data,
    input  logic [ROWS-1:0]        dn_valid,
    output logic [ROWS-1:0]        dn_ready,
    output logic [ROWS-1:0]        ack
);
    localparam int BURST_LEN  = STRIPE * VEC;
    localparam int BANK_WORDS = (QUOTA * VEC) / ROWS;
    localparam int AW         = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;
    localparam int BW         = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CW         = $clog2(QUOTA + 1);

    logic               swap, serving, rd_side, quota_met, wr_en;
    logic [BW-1:0]      wr_bank;
    logic [AW-1:0]      wr_ptr;
    logic [ROWS*AW-1:0] rd_addr;

    feeder_swap_ctl #(.ROWS(ROWS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .quota_met(quota_met),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .ack(ack),
        .swap(swap), .serving(serving), .rd_side(rd_side)
    );

    feeder_fill_seq #(
        .ROWS(ROWS), .VEC(VEC), .STRIPE(STRIPE), .QUOTA(QUOTA),
        .AW(AW), .BW(BW), .CW(CW)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .swap(swap),
        .ld_valid(ld_valid), .ld_ready(ld_ready),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_ptr(wr_ptr),
        .quota_met(quota_met)
    );

    feeder_store #(
        .ROWS(ROWS), .DATA_W(DATA_W), .VEC(VEC),
        .BANK_WORDS(BANK_WORDS), .AW(AW), .BW(BW)
    ) u_store (
        .clk(clk), .rd_side(rd_side), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_ptr(wr_ptr), .wr_data(ld_data), .rd_addr(rd_addr), .rd_data(rs_data)
    );

    for (genvar p = 0; p < ROWS; p++) begin : g_port
        feeder_burst_port #(
            .ROWS(ROWS), .REQ_W(REQ_W), .BURST_LEN(BURST_LEN), .AW(AW)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .serving(serving), .swap(swap),
            .rq_valid(rq_valid[p]), .rq_ready(rq_ready[p]),
            .rq_addr(rq_addr[p*REQ_W +: REQ_W]),
            .rs_valid(rs_valid[p]), .rs_ready(rs_ready[p]),
            .rd_addr(rd_addr[p*AW +: AW])
        );
    end

    assert_prime_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !serving |-> (rs_valid == '0 && rq_ready == '0));
endmodule

// File: tb/test_pingpong_tile_feeder.sv
module test_pingpong_tile_feeder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_ready;
    logic [15:0] ld_data = '0;
    logic [1:0]  rq_valid = '0;
    logic [1:0]  rq_ready;
    logic [7:0]  rq_addr = '0;
    logic [1:0]  rs_valid;
    logic [1:0]  rs_ready = '0;
    logic [15:0] rs_data;
    logic [1:0]  dn_valid = '0;
    logic [1:0]  dn_ready;
    logic [1:0]  ack;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pingpong_tile_feeder #(
        .ROWS(2), .DATA_W(8), .VEC(2), .STRIPE(2), .QUOTA(8), .REQ_W(4)
    ) i_pingpong_tile_feeder (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .ld_data(ld_data), .rq_valid(rq_valid), .rq_ready(rq_ready),
        .rq_addr(rq_addr), .rs_valid(rs_valid), .rs_ready(rs_ready),
        .rs_data(rs_data), .dn_valid(dn_valid), .dn_ready(dn_ready), .ack(ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Expected word k of burst for row address a, loaded in fill f.
    function automatic int exp_word(int f, int a, int k);
        return (f * 16 + 4 * a + k) & 8'hff;
    endfunction

    task automatic load_fill(input int f);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            ld_valid = 1'b1;
            ld_data  = {8'(f * 16 + 2 * k + 1), 8'(f * 16 + 2 * k)};
            #1;
            while (!ld_ready) begin @(negedge clk); #1; end
            @(posedge clk);
        end
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
    endtask

    task automatic read_burst(input int a, input int f, input bit stall);
        int p = a % 2;
        @(negedge clk);
        rq_valid[p] = 1'b1;
        rq_addr[p*4 +: 4] = 4'(a);
        #1;
        while (!rq_ready[p]) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        rq_valid[p] = 1'b0;
        #1;
        chk(rq_ready[p] == 1'b0, "R2 busy blocks request", int'(rq_ready[p]), 0);
        for (int k = 0; k < 4; k++) begin
            if (stall && k == 1) begin
                rs_ready[p] = 1'b0;
                @(negedge clk);
                #1;
            end
            rs_ready[p] = 1'b1;
            #1;
            chk(rs_valid[p] == 1'b1, "R4 reply valid in burst", int'(rs_valid[p]), 1);
            chk(int'(rs_data[p*8 +: 8]) == exp_word(f, a, k), "R1 R3 R4 reply word",
                int'(rs_data[p*8 +: 8]), exp_word(f, a, k));
            @(posedge clk);
            @(negedge clk);
        end
        rs_ready[p] = 1'b0;
        #1;
        chk(rs_valid[p] == 1'b0, "R4 burst ends", int'(rs_valid[p]), 0);
        chk(rq_ready[p] == 1'b1, "R2 port free after burst", int'(rq_ready[p]), 1);
    endtask

    task automatic send_done(input logic [1:0] m);
        @(negedge clk);
        dn_valid = m;
        @(posedge clk);
        @(negedge clk);
        dn_valid = '0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ld_ready == 1'b1, "R6 reset ld_ready", int'(ld_ready), 1);
        chk(rq_ready == 2'b00, "R9 reset rq_ready", int'(rq_ready), 0);
        chk(rs_valid == 2'b00, "R9 reset rs_valid", int'(rs_valid), 0);
        chk(ack == 2'b00, "R7 reset ack", int'(ack), 0);
        chk(dn_ready == 2'b00, "R7 prime dn_ready", int'(dn_ready), 0);

        // R9: requests during the first fill are refused.
        rq_valid = 2'b11;
        repeat (3) @(negedge clk);
        #1;
        chk(rq_ready == 2'b00, "R9 no accept while priming", int'(rq_ready), 0);
        rq_valid = 2'b00;

        // First fill: swaps on quota alone.
        load_fill(0);
        chk(ld_ready == 1'b0, "R6 quota stops loader", int'(ld_ready), 0);
        chk(rq_ready == 2'b00, "R10 no accept in swap cycle", int'(rq_ready), 0);
        @(negedge clk); #1;
        chk(ld_ready == 1'b1, "R8 swap clears beat count", int'(ld_ready), 1);
        chk(rq_ready == 2'b11, "R8 ports free after swap", int'(rq_ready), 3);
        chk(dn_ready == 2'b11, "R8 done flags clear", int'(dn_ready), 3);

        // Second fill: no swap without completion.
        load_fill(1);
        chk(ld_ready == 1'b0, "R6 quota stops loader", int'(ld_ready), 0);
        repeat (3) @(negedge clk);
        #1;
        chk(ld_ready == 1'b0, "R8 no swap before done", int'(ld_ready), 0);
        for (int a = 0; a < 4; a++) read_burst(a, 0, a[0]);

        send_done(2'b01);
        chk(ack == 2'b00, "R7 no ack on partial done", int'(ack), 0);
        chk(dn_ready == 2'b10, "R7 latched row blocks", int'(dn_ready), 2);
        send_done(2'b10);
        chk(ack == 2'b11, "R7 ack when all done", int'(ack), 3);
        chk(rq_ready == 2'b00, "R10 swap cycle blocks", int'(rq_ready), 0);
        @(negedge clk); #1;
        chk(ack == 2'b00, "R7 ack one cycle", int'(ack), 0);
        chk(dn_ready == 2'b11, "R8 done flags clear", int'(dn_ready), 3);
        chk(ld_ready == 1'b1, "R8 beat count clear", int'(ld_ready), 1);
        read_burst(2, 1, 1'b0);

        // R10: burst in flight is dropped by a swap.
        @(negedge clk);
        rq_valid[1] = 1'b1;
        rq_addr[7:4] = 4'd1;
        #1;
        while (!rq_ready[1]) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        rq_valid[1] = 1'b0;
        rs_ready[1] = 1'b1;
        #1;
        chk(int'(rs_data[15:8]) == exp_word(1, 1, 0), "R4 first word",
            int'(rs_data[15:8]), exp_word(1, 1, 0));
        @(posedge clk);
        @(negedge clk);
        rs_ready[1] = 1'b0;
        load_fill(2);
        chk(rs_valid[1] == 1'b1, "R4 burst held under stall", int'(rs_valid[1]), 1);
        send_done(2'b11);
        chk(ack == 2'b11, "R7 ack on joint done", int'(ack), 3);
        chk(rs_valid == 2'b00, "R10 no reply in swap cycle", int'(rs_valid), 0);
        @(negedge clk); #1;
        chk(rs_valid == 2'b00, "R10 burst dropped", int'(rs_valid), 0);
        chk(rq_ready == 2'b11, "R10 port idle after swap", int'(rq_ready), 3);
        read_burst(3, 2, 1'b0);

        // Completion before quota: ack now, swap later.
        send_done(2'b11);
        chk(ack == 2'b11, "R7 ack before quota", int'(ack), 3);
        chk(rq_ready == 2'b11, "R8 no swap before quota", int'(rq_ready), 3);
        @(negedge clk); #1;
        chk(ack == 2'b00, "R7 ack not repeated", int'(ack), 0);
        read_burst(0, 2, 1'b1);
        load_fill(3);
        chk(ack == 2'b00, "R7 no second ack", int'(ack), 0);
        chk(rq_ready == 2'b00, "R8 swap on quota after done", int'(rq_ready), 0);
        for (int a = 0; a < 4; a++) read_burst(a, 3, !a[0]);

        finished = 1'b1;
        summary();
    end
endmodule